// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling Converter Readout

This block is the digital control and readout side of a converter with two channels that sample at the same instant. An active-low convert-start input, on its falling edge, freezes the two selected input values and starts a conversion timed by a clock-cycle counter. A busy output stays high for the duration. A pair-select input, captured at the start, decides whether the first pair (A1, A2) or the second pair (B1, B2) is converted.

When the timer expires, both results are coded and latched in the same clock edge in which busy falls. A host then fetches them over a parallel bus with an active-low chip select and an active-low read strobe. The first read returns input 1 of the chosen pair and every later read returns input 2, until the next conversion starts. The converter core is outside the block. The raw values of the four inputs arrive on stand-in ports as straight binary codes, where midscale stands for zero volts.

Top module: `dual_sample_readout`

## Requirements
- R1: A conversion starts only when `conv_n` is seen high on one clock edge and low on the next. Holding `conv_n` low does not start a second conversion.
- R2: `busy` rises on the clock edge that accepts a start. It stays high for exactly `CONV_CYCLES` clock cycles.
- R3: `pair_sel` is sampled only when a start is accepted: 0 selects the A pair and 1 selects the B pair. Later changes have no effect on the result.
- R4: The raw input values are held at the accepted start. Changes on the raw inputs during the conversion do not alter the results.
- R5: After a conversion, the first read returns the coded value of input 1 of the chosen pair. The second read, and any later read, returns the coded value of input 2.
- R6: Both results become readable on the same clock edge in which `busy` falls.
- R7: `dout_en` is 1 and `dout` carries data only while `cs_n` and `rd_n` are both low. Otherwise `dout_en` is 0 and `dout` is all zeros. A strobe on `rd_n` with `cs_n` high does not advance the read order.
- R8: Each accepted start returns the read order to the first result.
- R9: A falling edge on `conv_n` while `busy` is high is ignored. It changes neither the busy length, the selected pair nor the results.
- R10: Raw codes are straight binary. With `UNIPOLAR`=0, the output is twos complement: bit 13 is inverted and bits 12..0 pass through. With `UNIPOLAR`=1, the raw code is passed through unchanged.
- R11: After reset, `busy` and `dout_en` are 0 and both stored results read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_n | input | 1 | Active-low convert start; its falling edge triggers a conversion |
| pair_sel | input | 1 | Input-pair choice captured at start (0 = A, 1 = B) |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| raw_a1 | input | 14 | Stand-in raw code, pair A input 1 |
| raw_a2 | input | 14 | Stand-in raw code, pair A input 2 |
| raw_b1 | input | 14 | Stand-in raw code, pair B input 1 |
| raw_b2 | input | 14 | Stand-in raw code, pair B input 2 |
| busy | output | 1 | High while a conversion runs |
| dout | output | 14 | Result data, zero when not driven |
| dout_en | output | 1 | Output-driver enable for `dout` |

## Verification
The bench builds two instances that share every input, both with `CONV_CYCLES`=20. One has `UNIPOLAR`=0 and the other has `UNIPOLAR`=1, so each random raw code checks both output codings side by side. The short conversion keeps the busy-length count cheap. It also leaves room to inject a second start edge in the middle of a conversion and to run many random conversions with three reads each. The default of 260 cycles is 5.2 µs at 50 MHz; the counter logic is the same at that value, only wider.

// File: rtl/dsr_pkg.sv
// Package for the dual-channel readout block.
// Holds the read-order type that the read port and its users share.
package dsr_pkg;
    typedef enum logic {
        PTR_FIRST  = 1'b0,
        PTR_SECOND = 1'b1
    } rd_ptr_e;
endpackage

// File: rtl/dsr_conv_timer.sv
// Convert-start edge detector and conversion timer.
// Assumes conv_n is already synchronous to clk. Accepts a falling edge
// only while idle. Holds busy high for CONV_CYCLES cycles and pulses
// done in the last one.
module dsr_conv_timer #(
    parameter int CONV_CYCLES = 260
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_n,
    output logic start_ok,
    output logic busy,
    output logic done
);
    localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

    logic          conv_q;
    logic [CW-1:0] cnt;

    // Accepted start: falling edge seen while no conversion runs
    assign start_ok = conv_q & ~conv_n & ~busy;
    assign done     = busy && (cnt == '0);

    // Remember the previous convert-start level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) conv_q <= 1'b1;
        else        conv_q <= conv_n;
    end

    // Busy flag and down-counter over the conversion window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start_ok) begin
            busy <= 1'b1;
            cnt  <= CW'(CONV_CYCLES - 1);
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dsr_sample_hold.sv
// Pair selection, sample hold and result latch.
// At an accepted start it captures the pair choice and the two raw codes
// of that pair. On done it codes both held values and stores them.
// Assumes raw codes are straight binary with midscale meaning zero.
module dsr_sample_hold #(
    parameter int DATA_W   = 14,
    parameter bit UNIPOLAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic              done,
    input  logic              pair_sel,
    input  logic [DATA_W-1:0] raw_a1,
    input  logic [DATA_W-1:0] raw_a2,
    input  logic [DATA_W-1:0] raw_b1,
    input  logic [DATA_W-1:0] raw_b2,
    output logic              sel_q,
    output logic [DATA_W-1:0] res1,
    output logic [DATA_W-1:0] res2
);
    logic [DATA_W-1:0] hold1, hold2;
    logic [DATA_W-1:0] code1, code2;

    // Output coding chosen by the range variant
    generate
        if (UNIPOLAR) begin : g_straight
            assign code1 = hold1;
            assign code2 = hold2;
        end else begin : g_twos
            assign code1 = {~hold1[DATA_W-1], hold1[DATA_W-2:0]};
            assign code2 = {~hold2[DATA_W-1], hold2[DATA_W-2:0]};
        end
    endgenerate

    // Freeze the pair choice and both sample values at conversion start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            hold1 <= '0;
            hold2 <= '0;
        end else if (start_ok) begin
            sel_q <= pair_sel;
            hold1 <= pair_sel ? raw_b1 : raw_a1;
            hold2 <= pair_sel ? raw_b2 : raw_a2;
        end
    end

    // Latch both coded results together at the end of conversion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res1 <= '0;
            res2 <= '0;
        end else if (done) begin
            res1 <= code1;
            res2 <= code2;
        end
    end
endmodule

// File: rtl/dsr_read_port.sv
// Parallel read port with a fixed result order.
// Drives data only during an active read (chip select and read low).
// Moves to the second result when a read ends and stays there.
// An accepted start returns it to the first result.
module dsr_read_port #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] res1,
    input  logic [DATA_W-1:0] res2,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    import dsr_pkg::*;

    rd_ptr_e ptr;
    logic    rd_act;
    logic    rd_q;

    assign rd_act  = ~cs_n & ~rd_n;
    assign dout_en = rd_act;

    // Select the result for the current read, zero when released
    always_comb begin
        if (!rd_act)               dout = '0;
        else if (ptr == PTR_FIRST) dout = res1;
        else                       dout = res2;
    end

    // Track the read strobe to find its trailing edge
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_act;
    end

    // Read order: reset on start, advance when a read ends
    always_ff @(posedge clk) begin
        if (!rst_n)               ptr <= PTR_FIRST;
        else if (start_ok)        ptr <= PTR_FIRST;
        else if (rd_q && !rd_act) ptr <= PTR_SECOND;
    end
endmodule

// File: rtl/dual_sample_readout.sv
// Top of the dual-channel simultaneous-sampling readout block.
// Ties the conversion timer, the sample/result store and the read port
// together. All inputs are assumed synchronous to clk.
module dual_sample_readout #(
    parameter int DATA_W      = 14,
    parameter int CONV_CYCLES = 260,
    parameter bit UNIPOLAR    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_n,
    input  logic              pair_sel,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] raw_a1,
    input  logic [DATA_W-1:0] raw_a2,
    input  logic [DATA_W-1:0] raw_b1,
    input  logic [DATA_W-1:0] raw_b2,
    output logic              busy,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    logic              start_ok;
    logic              done;
    logic              sel_q;
    logic [DATA_W-1:0] res1, res2;

    dsr_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n),
        .start_ok(start_ok), .busy(busy), .done(done)
    );

    dsr_sample_hold #(.DATA_W(DATA_W), .UNIPOLAR(UNIPOLAR)) u_store (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .done(done),
        .pair_sel(pair_sel), .raw_a1(raw_a1), .raw_a2(raw_a2),
        .raw_b1(raw_b1), .raw_b2(raw_b2), .sel_q(sel_q),
        .res1(res1), .res2(res2)
    );

    dsr_read_port #(.DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .cs_n(cs_n),
        .rd_n(rd_n), .res1(res1), .res2(res2), .dout(dout), .dout_en(dout_en)
    );
endmodule

// File: rtl/dsr_checker.sv
// Assertion checker for dual_sample_readout, attached by bind.
// Counts busy cycles itself so that no deep $past is needed.
module dsr_checker #(
    parameter int DATA_W      = 14,
    parameter int CONV_CYCLES = 260
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              start_ok,
    input logic              sel_q,
    input logic              cs_n,
    input logic              rd_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);
    int bcnt;

    // Length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= 0;
        else if (busy) bcnt <= bcnt + 1;
        else           bcnt <= 0;
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> busy); // R2
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == CONV_CYCLES)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < CONV_CYCLES)); // R9
    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sel_q)); // R3
    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!dout_en && dout == '0)); // R7
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start_ok); // R9
endmodule

bind dual_sample_readout dsr_checker #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start_ok(start_ok), .sel_q(sel_q),
    .cs_n(cs_n), .rd_n(rd_n), .dout(dout), .dout_en(dout_en)
);

// File: tb/dual_sample_readout_test.sv
// Bench: two instances (twos-complement and straight coding) on shared
// inputs; random conversions mixed with directed corner cases.
module dual_sample_readout_test;
    localparam int W = 14;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_n = 1'b1, pair_sel = 1'b0, cs_n = 1'b1, rd_n = 1'b1;
    logic [W-1:0] raw_a1 = '0, raw_a2 = '0, raw_b1 = '0, raw_b2 = '0;
    logic busy, busy_u, en, en_u;
    logic [W-1:0] dout, dout_u;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dual_sample_readout #(.DATA_W(W), .CONV_CYCLES(N), .UNIPOLAR(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .pair_sel(pair_sel),
        .cs_n(cs_n), .rd_n(rd_n), .raw_a1(raw_a1), .raw_a2(raw_a2),
        .raw_b1(raw_b1), .raw_b2(raw_b2), .busy(busy), .dout(dout), .dout_en(en)
    );
    dual_sample_readout #(.DATA_W(W), .CONV_CYCLES(N), .UNIPOLAR(1'b1)) uut_uni (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .pair_sel(pair_sel),
        .cs_n(cs_n), .rd_n(rd_n), .raw_a1(raw_a1), .raw_a2(raw_a2),
        .raw_b1(raw_b1), .raw_b2(raw_b2), .busy(busy_u), .dout(dout_u), .dout_en(en_u)
    );

    function automatic logic [W-1:0] twos(input logic [W-1:0] v);
        return {~v[W-1], v[W-2:0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual=%0d expected<150000", cycles);
                finish_run();
            end
        end
    end

    // One read cycle: strobe for one clock, sample, release, wait one clock
    task automatic do_read(output logic [W-1:0] d, output logic [W-1:0] du, output logic e);
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        d = dout; du = dout_u; e = en;
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    // Conversion with optional mid-busy retrigger and held-low start
    task automatic do_conv(input logic sel, input logic [W-1:0] a1, input logic [W-1:0] a2,
                           input logic [W-1:0] b1, input logic [W-1:0] b2,
                           input bit retrig, input bit hold_low);
        int blen;
        raw_a1 = a1; raw_a2 = a2; raw_b1 = b1; raw_b2 = b2;
        pair_sel = sel; conv_n = 1'b0;
        @(negedge clk);
        chk("R2 busy rises", int'(busy), 1);
        if (!hold_low) conv_n = 1'b1;
        pair_sel = ~sel;                                  // R3 late change
        raw_a1 = W'($urandom); raw_a2 = W'($urandom);     // R4 late change
        raw_b1 = W'($urandom); raw_b2 = W'($urandom);
        blen = 1;
        while (busy && blen < 1000) begin
            @(negedge clk);
            if (retrig && blen == 5) conv_n = 1'b0;       // R9 edge in busy
            if (retrig && blen == 6) conv_n = 1'b1;
            if (busy) blen++;
        end
        chk("R2 busy length", blen, N);
        if (hold_low) begin
            repeat (4) begin
                @(negedge clk);
                chk("R1 held low no restart", int'(busy), 0);
            end
            conv_n = 1'b1;
            @(negedge clk);
        end
    endtask

    // Full conversion plus three reads checked on both codings
    task automatic conv_and_check(input logic sel, input bit retrig, input bit hold_low);
        logic [W-1:0] a1, a2, b1, b2, x1, x2, d, du;
        logic e;
        a1 = W'($urandom); a2 = W'($urandom);
        b1 = W'($urandom); b2 = W'($urandom);
        x1 = sel ? b1 : a1;
        x2 = sel ? b2 : a2;
        do_conv(sel, a1, a2, b1, b2, retrig, hold_low);
        do_read(d, du, e);
        chk("R7 enable on read", int'(e), 1);
        chk("R5 first read", int'(du), int'(x1));
        chk("R10 twos first", int'(d), int'(twos(x1)));
        do_read(d, du, e);
        chk("R5 second read", int'(du), int'(x2));
        chk("R10 twos second", int'(d), int'(twos(x2)));
        do_read(d, du, e);
        chk("R5 third read repeats second", int'(du), int'(x2));
    endtask

    initial begin
        logic [W-1:0] d, du;
        logic e;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy after reset", int'(busy), 0);
        chk("R11 enable after reset", int'(en), 0);
        do_read(d, du, e);
        chk("R11 result zero", int'(d), 0);
        chk("R11 result zero uni", int'(du), 0);

        // R6: results visible on the first idle cycle after busy falls
        raw_a1 = 14'h2000; raw_a2 = 14'h1FFF; pair_sel = 1'b0; conv_n = 1'b0;
        @(negedge clk);
        conv_n = 1'b1;
        while (busy) @(negedge clk);
        do_read(d, du, e);
        chk("R6 result at busy fall", int'(d), 14'h0000);
        chk("R10 midscale uni", int'(du), 14'h2000);
        do_read(d, du, e);
        chk("R10 below midscale twos", int'(d), 14'h3FFF);

        // Directed: both pairs, extreme codes
        do_conv(1'b1, 14'h0, 14'h0, 14'h3FFF, 14'h0000, 1'b0, 1'b0);
        do_read(d, du, e);
        chk("R3 B pair first", int'(du), 14'h3FFF);
        chk("R10 full scale twos", int'(d), 14'h1FFF);
        do_read(d, du, e);
        chk("R10 zero code twos", int'(d), 14'h2000);

        // R7: read strobe without chip select is ignored
        do_conv(1'b0, 14'h0123, 14'h0456, 14'h0, 14'h0, 1'b0, 1'b0);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R7 no enable without cs", int'(en), 0);
        chk("R7 bus zero without cs", int'(dout_u), 0);
        rd_n = 1'b1;
        @(negedge clk);
        do_read(d, du, e);
        chk("R7 order not advanced", int'(du), 14'h0123);

        // R8: new start returns order to first result
        do_read(d, du, e);
        chk("R8 second before restart", int'(du), 14'h0456);
        do_conv(1'b0, 14'h0AAA, 14'h0555, 14'h0, 14'h0, 1'b0, 1'b0);
        do_read(d, du, e);
        chk("R8 first after restart", int'(du), 14'h0AAA);

        // R9 retrigger during busy, R1 start held low
        conv_and_check(1'b0, 1'b1, 1'b0);
        conv_and_check(1'b1, 1'b1, 1'b0);
        conv_and_check(1'b1, 1'b0, 1'b1);

        // Random conversions
        for (int i = 0; i < 40; i++) begin
            conv_and_check(1'($urandom), 1'($urandom_range(0, 3) == 0), 1'b0);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        chk("R2 instances agree on busy", int'(busy_u), int'(busy));
        finish_run();
    end
endmodule